// File: doc/BRIEF.md
# Dual Clock Supervisor with RC Fallback

The block watches two oscillator clocks, a fast main clock and a slow sub clock, from a free-running RC reference clock. Each monitored clock flips a toggle bit in its own domain. The bit is synchronised into the RC domain, and a counter measures how long it has been quiet. When a clock stays quiet for a set number of RC cycles, the block raises a sticky loss flag for it. It then hands that clock's output over to the RC clock through a multiplexer that holds its output low between the two sources.

The main-clock watch pauses while the chip runs in sub-clock mode. After the return to main-clock mode, the watch restarts at whichever comes first: a rising edge of the oscillator-stable signal, or an RC-timed wake-up timeout. A policy bit decides what happens when the chip enters sub-clock mode after the sub clock has already been flagged as lost. With the bit at 0 the RC clock is used in its place and no reset is raised. With the bit at 1 the block issues a reset request.

Top module: `dcs_clock_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `main_lost`, `sub_lost`, `sub_on_rc` and `rst_req` are 0, and each clock output is equal to its own source clock.
- R2: In main-clock mode, with `main_sv_en`=1 and the watch armed, a main clock that stops for more than IDLE_LIMIT RC cycles (default 8) sets `main_lost`. After the handover, `main_clk_out` carries the RC clock.
- R3: With `sub_sv_en`=1, a sub clock that stops for more than IDLE_LIMIT RC cycles sets `sub_lost`. In the next cycle `sub_on_rc` reads 1, and after the handover `sub_clk_out` carries the RC clock.
- R4: The loss flags are sticky. Only reset or a one-cycle `flag_clr`=1 clears them, and the clear takes effect at the next RC edge. When a flag clears, its output goes back to the real clock.
- R5: While `sub_mode`=1 (sub-clock mode), main-clock supervision is suspended, so a stopped main clock never sets `main_lost`. The value of `main_sv_en` is left unchanged.
- R6: After `sub_mode` falls to 0, main-clock supervision restarts on the first rising edge of `osc_stable`, even when that edge comes long before the timeout.
- R7: If `osc_stable` does not rise, supervision restarts WAKE_TIMEOUT RC cycles (default 64) after `sub_mode` falls. The timeout count restarts from zero on every return to main-clock mode.
- R8: With `rst_policy`=0, entering sub-clock mode with `sub_lost` set raises no `rst_req`, and the RC clock serves as the sub clock.
- R9: With `rst_policy`=1, a 0-to-1 change of `sub_mode` while `sub_lost` is set gives exactly one `rst_req` pulse, one RC cycle long. With `sub_lost` clear, no pulse is given.
- R10: Each handover between a source clock and the RC clock holds the output low for at least one full RC cycle.
- R11: With `main_sv_en`=0 or `sub_sv_en`=0, a stopped clock of that kind sets no loss flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Free-running RC reference clock; all control logic runs on it |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| main_clk | input | 1 | Main oscillator clock under watch |
| sub_clk | input | 1 | Sub oscillator clock under watch |
| osc_stable | input | 1 | Oscillator-stable indication; its rising edge re-arms the main watch |
| main_sv_en | input | 1 | Enable for main-clock supervision |
| sub_sv_en | input | 1 | Enable for sub-clock supervision |
| rst_policy | input | 1 | 1: reset request on entry to sub mode with a lost sub clock; 0: silent RC substitution |
| sub_mode | input | 1 | Requested clock mode, 1 = sub-clock mode, 0 = main-clock mode |
| flag_clr | input | 1 | Software clear of both loss flags |
| main_clk_out | output | 1 | Main clock, or the RC clock after a main loss |
| sub_clk_out | output | 1 | Sub clock, or the RC clock after a sub loss |
| main_lost | output | 1 | Sticky main-clock loss flag |
| sub_lost | output | 1 | Sticky sub-clock loss flag |
| sub_on_rc | output | 1 | 1 while the sub output is not driven by the real sub clock |
| rst_req | output | 1 | One-RC-cycle reset request |

## Verification
The bound checker watches, on every RC cycle, the properties that do not depend on the scenario: the flags stay sticky, a clear takes effect, the reset request lasts one cycle and appears only under the right policy and mode change, the main flag cannot rise while the watch is suspended, and the output is low during the second gap state of each handover. Only the directed scenarios can show how long detection takes, that the output carries the RC clock after a loss, and that the watch restarts early on `osc_stable` or late on the timeout. They also show the two reset policies and the effect of the enable bits.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // Handover multiplexer: two gap states keep the output low between sources
  typedef enum logic [1:0] {MX_SRC, MX_GAP_A, MX_GAP_B, MX_RC} mux_st_e;
  // Main-watch arming state
  typedef enum logic [1:0] {AW_ON, AW_HOLD, AW_WAKE} arm_st_e;
endpackage

// File: rtl/dcs_idle_watch.sv
module dcs_idle_watch #(
  parameter int IDLE_LIMIT = 8
) (
  input  logic rc_clk,
  input  logic rst_n,
  input  logic mon_clk,
  input  logic active,
  input  logic clr,
  output logic lost
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic          tog_q;
  logic [2:0]    smp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lost_q, lost_d;
  logic          seen;

  // toggle bit in the watched domain
  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;

  assign seen = smp_q[2] ^ smp_q[1];

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (clr) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else begin
      if (!active || seen)  cnt_d = '0;
      else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
      if (cnt_q == LIM)     lost_d = 1'b1;
    end
  end

  always_ff @(posedge rc_clk or negedge rst_n)
    if (!rst_n) begin
      smp_q  <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      smp_q  <= {smp_q[1:0], tog_q};
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end

  assign lost = lost_q;
endmodule

// File: rtl/dcs_main_arm.sv
module dcs_main_arm
  import dcs_pkg::*;
#(
  parameter int WAKE_TIMEOUT = 64
) (
  input  logic rc_clk,
  input  logic rst_n,
  input  logic sub_mode,
  input  logic osc_stable,
  output logic armed
);
  localparam int TW = $clog2(WAKE_TIMEOUT + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(WAKE_TIMEOUT - 1);

  arm_st_e       st_q, st_d;
  logic [TW-1:0] to_q, to_d;
  logic [2:0]    osc_q;
  logic          osc_rise;

  assign osc_rise = osc_q[1] & ~osc_q[2];

  always_comb begin
    st_d = st_q;
    to_d = '0;
    case (st_q)
      AW_ON:   if (sub_mode) st_d = AW_HOLD;
      AW_HOLD: if (!sub_mode) st_d = AW_WAKE;
      AW_WAKE: begin
        to_d = to_q + 1'b1;
        if (sub_mode)                           st_d = AW_HOLD;
        else if (osc_rise || to_q == TO_LAST)   st_d = AW_ON;
      end
      default: st_d = AW_ON;
    endcase
  end

  always_ff @(posedge rc_clk or negedge rst_n)
    if (!rst_n) begin
      st_q  <= AW_ON;
      to_q  <= '0;
      osc_q <= '0;
    end else begin
      st_q  <= st_d;
      to_q  <= to_d;
      osc_q <= {osc_q[1:0], osc_stable};
    end

  assign armed = (st_q == AW_ON);
endmodule

// File: rtl/dcs_handover_mux.sv
module dcs_handover_mux
  import dcs_pkg::*;
(
  input  logic    rc_clk,
  input  logic    rst_n,
  input  logic    src_clk,
  input  logic    want_rc,
  output logic    out_clk,
  output logic    on_rc,
  output mux_st_e st
);
  mux_st_e st_q, st_d;
  logic    rc_en_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      MX_SRC:   if (want_rc)  st_d = MX_GAP_A;
      MX_GAP_A: st_d = MX_GAP_B;
      MX_GAP_B: st_d = want_rc ? MX_RC : MX_SRC;
      MX_RC:    if (!want_rc) st_d = MX_GAP_A;
      default:  st_d = MX_SRC;
    endcase
  end

  always_ff @(posedge rc_clk or negedge rst_n)
    if (!rst_n) st_q <= MX_SRC;
    else        st_q <= st_d;

  // RC gate changes only while rc_clk is low
  always_ff @(negedge rc_clk or negedge rst_n)
    if (!rst_n) rc_en_q <= 1'b0;
    else        rc_en_q <= (st_q == MX_RC);

  assign out_clk = (src_clk & (st_q == MX_SRC)) | (rc_clk & rc_en_q);
  assign on_rc   = (st_q != MX_SRC);
  assign st      = st_q;
endmodule

// File: rtl/dcs_clock_guard.sv
module dcs_clock_guard
  import dcs_pkg::*;
#(
  parameter int IDLE_LIMIT   = 8,
  parameter int WAKE_TIMEOUT = 64
) (
  input  logic rc_clk,
  input  logic rst_n,
  input  logic main_clk,
  input  logic sub_clk,
  input  logic osc_stable,
  input  logic main_sv_en,
  input  logic sub_sv_en,
  input  logic rst_policy,
  input  logic sub_mode,
  input  logic flag_clr,
  output logic main_clk_out,
  output logic sub_clk_out,
  output logic main_lost,
  output logic sub_lost,
  output logic sub_on_rc,
  output logic rst_req
);
  localparam int NCH = 2;  // 0: main, 1: sub

  logic [1:0]     rsync_q;
  logic           rst_rc_n;
  logic           main_armed;
  logic [NCH-1:0] src, act, lost, outc, onrc;
  mux_st_e        mux_st [NCH];
  logic           mode_q, req_q, req_d;

  // reset: asserted at once, released on an RC edge
  always_ff @(posedge rc_clk or negedge rst_n)
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  assign rst_rc_n = rsync_q[1];

  dcs_main_arm #(.WAKE_TIMEOUT(WAKE_TIMEOUT)) u_arm (
    .rc_clk(rc_clk), .rst_n(rst_rc_n), .sub_mode(sub_mode),
    .osc_stable(osc_stable), .armed(main_armed)
  );

  assign src = {sub_clk, main_clk};
  assign act = {sub_sv_en, main_sv_en & main_armed};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dcs_idle_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_watch (
      .rc_clk(rc_clk), .rst_n(rst_rc_n), .mon_clk(src[g]),
      .active(act[g]), .clr(flag_clr), .lost(lost[g])
    );
    dcs_handover_mux u_mux (
      .rc_clk(rc_clk), .rst_n(rst_rc_n), .src_clk(src[g]),
      .want_rc(lost[g]), .out_clk(outc[g]), .on_rc(onrc[g]), .st(mux_st[g])
    );
  end

  // reset request on entry into sub-clock mode
  always_comb begin
    req_d = sub_mode & ~mode_q & lost[1] & rst_policy;
  end

  always_ff @(posedge rc_clk or negedge rst_rc_n)
    if (!rst_rc_n) begin
      mode_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      mode_q <= sub_mode;
      req_q  <= req_d;
    end

  assign main_clk_out = outc[0];
  assign sub_clk_out  = outc[1];
  assign main_lost    = lost[0];
  assign sub_lost     = lost[1];
  assign sub_on_rc    = onrc[1];
  assign rst_req      = req_q;
endmodule

// File: rtl/dcs_guard_chk.sv
module dcs_guard_chk
  import dcs_pkg::*;
(
  input logic    rc_clk,
  input logic    rst_n,
  input logic    sub_mode,
  input logic    rst_policy,
  input logic    flag_clr,
  input logic    main_lost,
  input logic    sub_lost,
  input logic    sub_on_rc,
  input logic    rst_req,
  input logic    main_clk_out,
  input logic    sub_clk_out,
  input logic    main_armed,
  input mux_st_e st_main,
  input mux_st_e st_sub
);
  p_sticky_main_r4: assert property (@(posedge rc_clk) disable iff (!rst_n)
    main_lost && !flag_clr |=> main_lost);
  p_sticky_sub_r4: assert property (@(posedge rc_clk) disable iff (!rst_n)
    sub_lost && !flag_clr |=> sub_lost);
  p_clear_r4: assert property (@(posedge rc_clk) disable iff (!rst_n)
    flag_clr |=> !main_lost && !sub_lost);
  p_status_r3: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $rose(sub_lost) |=> sub_on_rc);
  p_suspend_r5: assert property (@(posedge rc_clk) disable iff (!rst_n)
    !main_armed && !$past(main_armed) && !$past(main_armed, 2) |-> !$rose(main_lost));
  p_pulse_r9: assert property (@(posedge rc_clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_cause_r9: assert property (@(posedge rc_clk) disable iff (!rst_n)
    rst_req |-> $past(rst_policy) && $past(sub_lost) && $past(sub_mode) && !$past(sub_mode, 2));
  p_gap_main_r10: assert property (@(posedge rc_clk) disable iff (!rst_n)
    st_main == MX_GAP_B |-> !main_clk_out);
  p_gap_sub_r10: assert property (@(posedge rc_clk) disable iff (!rst_n)
    st_sub == MX_GAP_B |-> !sub_clk_out);
endmodule

bind dcs_clock_guard dcs_guard_chk u_chk (
  .rc_clk(rc_clk), .rst_n(rst_n), .sub_mode(sub_mode), .rst_policy(rst_policy),
  .flag_clr(flag_clr), .main_lost(main_lost), .sub_lost(sub_lost),
  .sub_on_rc(sub_on_rc), .rst_req(rst_req), .main_clk_out(main_clk_out),
  .sub_clk_out(sub_clk_out), .main_armed(main_armed),
  .st_main(mux_st[0]), .st_sub(mux_st[1])
);

// File: tb/dcs_clock_guard_tb.sv
`timescale 1ns/100ps
module dcs_clock_guard_tb;
  logic rc_clk = 1'b0;
  logic rst_n, main_clk, sub_clk, osc_stable, main_sv_en, sub_sv_en;
  logic rst_policy, sub_mode, flag_clr;
  logic main_clk_out, sub_clk_out, main_lost, sub_lost, sub_on_rc, rst_req;
  logic main_run, sub_run;
  int total = 0;
  int bad = 0;

  dcs_clock_guard u_dut (
    .rc_clk(rc_clk), .rst_n(rst_n), .main_clk(main_clk), .sub_clk(sub_clk),
    .osc_stable(osc_stable), .main_sv_en(main_sv_en), .sub_sv_en(sub_sv_en),
    .rst_policy(rst_policy), .sub_mode(sub_mode), .flag_clr(flag_clr),
    .main_clk_out(main_clk_out), .sub_clk_out(sub_clk_out),
    .main_lost(main_lost), .sub_lost(sub_lost), .sub_on_rc(sub_on_rc),
    .rst_req(rst_req)
  );

  always #2.5 rc_clk = ~rc_clk;  // 200 MHz

  // watched clocks, offset so they never change at a sample point
  initial begin
    main_clk = 1'b0;
    #0.3;
    forever begin #4; if (main_run) main_clk = ~main_clk; end
  end
  initial begin
    sub_clk = 1'b0;
    #0.2;
    forever begin #5.5; if (sub_run) sub_clk = ~sub_clk; end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge rc_clk);
    #1;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(4);
  endtask

  task automatic count_req(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin tick(1); if (rst_req) c++; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; main_run = 1'b1; sub_run = 1'b1; osc_stable = 1'b0;
    main_sv_en = 1'b1; sub_sv_en = 1'b1; rst_policy = 1'b0; sub_mode = 1'b0;
    flag_clr = 1'b0;
    tick(3);
    chk("R1 main_lost in reset", main_lost, 1'b0);
    chk("R1 rst_req in reset", rst_req, 1'b0);
    rst_n = 1'b1;
    tick(20);
    chk("R1 main_lost", main_lost, 1'b0);
    chk("R1 sub_lost", sub_lost, 1'b0);
    chk("R1 sub_on_rc", sub_on_rc, 1'b0);
    chk("R1 rst_req", rst_req, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 main passthrough", main_clk_out, main_clk);
      chk("R1 sub passthrough", sub_clk_out, sub_clk);
      tick(1);
    end
  endtask

  task automatic t_main_loss();
    main_run = 1'b0;
    tick(6);
    chk("R2 no early main flag", main_lost, 1'b0);
    tick(14);
    chk("R2 main_lost", main_lost, 1'b1);
    chk("R2 sub unaffected", sub_lost, 1'b0);
    tick(6);
    chk("R2 RC high phase on main out", main_clk_out, 1'b1);
    #2;
    chk("R2 RC low phase on main out", main_clk_out, 1'b0);
    main_run = 1'b1;
    tick(30);
    chk("R4 main flag sticky", main_lost, 1'b1);
    clear_flags();
    chk("R4 main flag cleared", main_lost, 1'b0);
    tick(6);
    for (int i = 0; i < 3; i++) begin
      chk("R4 main back on real clock", main_clk_out, main_clk);
      tick(1);
    end
  endtask

  task automatic t_suspend_timeout();
    sub_mode = 1'b1; tick(4);
    main_run = 1'b0; tick(40);
    chk("R5 no main flag in sub mode", main_lost, 1'b0);
    chk("R5 enable bit kept", main_sv_en, 1'b1);
    sub_mode = 1'b0; tick(40);
    chk("R7 still suspended before timeout", main_lost, 1'b0);
    tick(50);
    chk("R7 flag after timeout", main_lost, 1'b1);
    main_run = 1'b1; tick(10);
    clear_flags();
  endtask

  task automatic t_osc_rearm();
    sub_mode = 1'b1; tick(4);
    main_run = 1'b0; tick(10);
    sub_mode = 1'b0; tick(10);
    chk("R6 not yet armed", main_lost, 1'b0);
    osc_stable = 1'b1; tick(25);
    chk("R6 armed by osc_stable", main_lost, 1'b1);
    osc_stable = 1'b0;
    main_run = 1'b1; tick(10);
    clear_flags();
  endtask

  task automatic t_sub_policy0();
    int c;
    sub_run = 1'b0; tick(25);
    chk("R3 sub_lost", sub_lost, 1'b1);
    chk("R3 sub_on_rc", sub_on_rc, 1'b1);
    chk("R3 main unaffected", main_lost, 1'b0);
    sub_mode = 1'b1;
    count_req(12, c);
    chk("R8 no reset with policy 0", (c == 0), 1'b1);
    chk("R8 RC high phase on sub out", sub_clk_out, 1'b1);
    #2;
    chk("R8 RC low phase on sub out", sub_clk_out, 1'b0);
    tick(1);
    sub_mode = 1'b0; tick(4);
  endtask

  task automatic t_sub_policy1();
    int c;
    rst_policy = 1'b1;
    sub_mode = 1'b1;
    count_req(12, c);
    if (c != 1) begin
      total++; bad++;
      $display("FAIL R9 pulse count actual=%0d expected=1", c);
    end else total++;
    sub_mode = 1'b0; tick(4);
    sub_run = 1'b1; tick(10);
    clear_flags();
    tick(4);
    chk("R4 sub_on_rc back to 0", sub_on_rc, 1'b0);
    chk("R4 sub back on real clock", sub_clk_out, sub_clk);
    sub_mode = 1'b1;
    count_req(12, c);
    chk("R9 no pulse with healthy sub clock", (c == 0), 1'b1);
    sub_mode = 1'b0; rst_policy = 1'b0; tick(4);
  endtask

  task automatic t_enables();
    main_sv_en = 1'b0; main_run = 1'b0; tick(100);
    chk("R11 main disabled, no flag", main_lost, 1'b0);
    main_run = 1'b1; tick(5); main_sv_en = 1'b1;
    sub_sv_en = 1'b0; sub_run = 1'b0; tick(40);
    chk("R11 sub disabled, no flag", sub_lost, 1'b0);
    chk("R10 sub stays on source", sub_on_rc, 1'b0);
    sub_run = 1'b1; tick(5); sub_sv_en = 1'b1; tick(10);
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_main_loss();
    t_suspend_timeout();
    t_osc_rearm();
    t_sub_policy0();
    t_sub_policy1();
    t_enables();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule